// File: doc/BRIEF.md
# AUX Request Framer

This block turns one request descriptor for a display auxiliary channel into the exact byte sequence a channel controller shifts onto the wire. A descriptor carries a 4-bit request code, a 20-bit target address and a byte length. Write requests also carry a payload, which the block pulls one byte at a time from a streaming source. The framer packs the code and address into a three-byte address field. It appends a length byte when the length is nonzero, then appends any write payload. It reports the total transmit size and the receive size to expect. Descriptors whose transmit or receive size would not fit the 20-byte channel buffer are refused.

On the way back, the block consumes the reply bytes of the same transaction. It extracts the reply code and, for writes, the number of bytes the target says it accepted. For reads, it passes the returned data bytes out, but only when the reply is an acknowledge. Retry decisions, link training and the meaning of bridged serial-bus requests belong to the surrounding logic.

Top module: `aux_req_framer`

## Requirements
- R1: After reset, `tx_valid`, `tx_last`, `req_reject`, `pay_take`, `rd_valid` and `rsp_done` are low and `req_ready` is high.
- R2: The first transmitted byte is `{req_code, req_addr[19:16]}`, the second is `req_addr[15:8]`, the third is `req_addr[7:0]`.
- R3: A fourth byte equal to `req_len - 1` is sent only when `req_len` is nonzero. A zero-length request of either kind sends exactly the three address bytes.
- R4: Bit 0 of `req_code` equal to 0 marks a write. A write with nonzero length sends `4 + req_len` bytes, with the payload bytes in the order supplied after the fourth byte. `pay_take` is high for exactly `req_len` cycles, and `rx_expect` is 2.
- R5: Bit 0 of `req_code` equal to 1 marks a read. A read sends 4 bytes when the length is nonzero and 3 otherwise, never raises `pay_take`, and sets `rx_expect` to `req_len + 1`.
- R6: An accepted stream is presented one byte per cycle with no gaps, starting two cycles after acceptance. `tx_last` marks its final byte, and `tx_count` equals the number of bytes in the stream.
- R7: A write with `req_len` above 16 or a read with `req_len` above 19 is refused. `req_reject` pulses for one cycle, no byte is transmitted, no payload is taken, and `req_ready` stays high.
- R8: `rsp_code` is the upper nibble of the first reply byte. `rsp_done` pulses in the cycle after the byte marked `rx_last`.
- R9: For a write, `rsp_wcount` is the second reply byte clamped to the requested length. When the reply has only one byte, it is the requested length. `rsp_rcount` is 0.
- R10: For a read whose reply code is 0 (acknowledge), the reply bytes from the second onward appear on `rd_data` in order, up to the requested length, and `rsp_rcount` counts them. Surplus bytes are dropped.
- R11: For a read whose reply code is nonzero, `rd_valid` stays low and `rsp_rcount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Descriptor present; taken when `req_ready` is high |
| req_code | input | 4 | Request code; bit 0 set means read |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Payload or read length in bytes |
| req_ready | output | 1 | Framer idle, able to take a descriptor |
| req_reject | output | 1 | One-cycle pulse: descriptor refused for size |
| pay_take | output | 1 | `pay_data` is consumed at this clock edge |
| pay_data | input | 8 | Write payload byte |
| tx_valid | output | 1 | `tx_data` holds a stream byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the stream |
| tx_count | output | 5 | Total bytes in the current stream |
| rx_expect | output | 5 | Reply size to expect for the accepted request |
| rx_valid | input | 1 | Reply byte present |
| rx_data | input | 8 | Reply byte |
| rx_last | input | 1 | Final reply byte |
| rsp_done | output | 1 | One-cycle pulse: reply decoded |
| rsp_code | output | 4 | Decoded reply code |
| rsp_wcount | output | 5 | Bytes written, for a write |
| rsp_rcount | output | 5 | Read bytes passed out |
| rd_valid | output | 1 | `rd_data` holds a read data byte |
| rd_data | output | 8 | Read data byte |

## Verification
The bench goes after the length boundaries on both sides of each limit: 16 against 17 for writes, 19 against 20 for reads, and zero. An off-by-one in the size check would either refuse a legal 20-byte stream or emit an oversized one. A framer that always sent the length byte would give zero-length requests four bytes. Replies are sent with a single byte, with a written count larger than the request, and with more read data than requested. A decoder without the clamp or the surplus cut would report counts above the request. Non-acknowledge read replies carrying data would expose a decoder that forwards bytes without looking at the reply code.

// File: rtl/aux_frm_pkg.sv
// Shared constants and types for the AUX request framer.
package aux_frm_pkg;
    localparam int          ADDR_W    = 20;
    localparam int          CODE_W    = 4;
    localparam int          HDR_FULL  = 4;
    localparam int          HDR_BARE  = 3;
    localparam logic [3:0]  REPLY_ACK = 4'h0;

    typedef enum logic [0:0] {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;
endpackage

// File: rtl/aux_hdr_gen.sv
// aux_hdr_gen: combinational descriptor decode. Builds the four header
// bytes, the header length in use, transmit and receive sizes, and the
// oversize verdict. Assumes MAX_XFER fits in CNT_W bits.
module aux_hdr_gen #(
    parameter int LEN_W    = 5,
    parameter int CNT_W    = 5,
    parameter int MAX_XFER = 20
) (
    input  logic [aux_frm_pkg::CODE_W-1:0] code,
    input  logic [aux_frm_pkg::ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]               len,
    output logic [3:0][7:0]                hdr,
    output logic [2:0]                     hdr_n,
    output logic [CNT_W-1:0]               tx_n,
    output logic [CNT_W-1:0]               rx_n,
    output logic                           is_read,
    output logic                           too_big
);
    import aux_frm_pkg::*;

    localparam int WR_LEN_MAX = MAX_XFER - HDR_FULL;
    localparam int RD_LEN_MAX = MAX_XFER - 1;

    // Header byte packing: code and top address nibble, then address bytes, then length-1.
    always_comb begin
        hdr[0] = {code, addr[19:16]};
        hdr[1] = addr[15:8];
        hdr[2] = addr[7:0];
        hdr[3] = 8'(len) - 8'd1;
        hdr_n  = (len != '0) ? 3'(HDR_FULL) : 3'(HDR_BARE);
    end

    // Size computation and limit check, split by direction.
    always_comb begin
        is_read = code[0];
        if (is_read) begin
            tx_n    = CNT_W'(hdr_n);
            rx_n    = CNT_W'(len) + CNT_W'(1);
            too_big = int'(len) > RD_LEN_MAX;
        end else begin
            tx_n    = (len != '0) ? CNT_W'(len) + CNT_W'(HDR_FULL) : CNT_W'(HDR_BARE);
            rx_n    = CNT_W'(2);
            too_big = int'(len) > WR_LEN_MAX;
        end
    end
endmodule

// File: rtl/aux_tx_seq.sv
// aux_tx_seq: takes an accepted descriptor, holds its header and sizes,
// and emits the stream one byte per cycle: header bytes first, then
// payload bytes pulled from pay_data while pay_take is high. Assumes the
// payload source always has a byte ready when asked. Also keeps the
// request context that the reply decoder needs.
module aux_tx_seq #(
    parameter int LEN_W = 5,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_go,
    input  logic             too_big,
    input  logic [3:0][7:0]  hdr_in,
    input  logic [2:0]       hdr_n_in,
    input  logic [CNT_W-1:0] tx_n_in,
    input  logic [CNT_W-1:0] rx_n_in,
    input  logic             is_read_in,
    input  logic [LEN_W-1:0] len_in,
    input  logic [7:0]       pay_data,
    output logic             ready,
    output logic             pay_take,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic [CNT_W-1:0] tx_count,
    output logic             rej,
    output logic             ctx_read,
    output logic [LEN_W-1:0] ctx_len,
    output logic [CNT_W-1:0] ctx_rxn
);
    import aux_frm_pkg::*;

    tx_state_e        st;
    logic [CNT_W-1:0] idx;
    logic [3:0][7:0]  hdr_q;
    logic [2:0]       hdr_n_q;
    logic             at_end;

    // Idle indication and payload pull: payload follows the header bytes.
    always_comb begin
        ready    = (st == TX_IDLE);
        pay_take = (st == TX_SEND) && (idx >= CNT_W'(hdr_n_q));
        at_end   = (idx == tx_count - CNT_W'(1));
    end

    // Sequencer: accept or refuse a descriptor, then step through the stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= TX_IDLE;
            idx      <= '0;
            hdr_q    <= '0;
            hdr_n_q  <= '0;
            tx_count <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
            tx_last  <= 1'b0;
            rej      <= 1'b0;
            ctx_read <= 1'b0;
            ctx_len  <= '0;
            ctx_rxn  <= '0;
        end else begin
            rej      <= 1'b0;
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            case (st)
                TX_IDLE: begin
                    if (req_go) begin
                        if (too_big) begin
                            rej <= 1'b1;
                        end else begin
                            hdr_q    <= hdr_in;
                            hdr_n_q  <= hdr_n_in;
                            tx_count <= tx_n_in;
                            idx      <= '0;
                            ctx_read <= is_read_in;
                            ctx_len  <= len_in;
                            ctx_rxn  <= rx_n_in;
                            st       <= TX_SEND;
                        end
                    end
                end
                TX_SEND: begin
                    tx_valid <= 1'b1;
                    tx_data  <= pay_take ? pay_data : hdr_q[idx[1:0]];
                    tx_last  <= at_end;
                    idx      <= idx + CNT_W'(1);
                    if (at_end) st <= TX_IDLE;
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    // R7
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rej |-> (!tx_valid && !pay_take));
    // R6
    stream_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_last) |=> tx_valid);
    // R6
    last_in_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);
    // R5
    no_read_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_take |-> !ctx_read);
endmodule

// File: rtl/aux_rx_dec.sv
// aux_rx_dec: decodes the reply stream against the stored request
// context. First byte gives the reply code; for writes the second byte
// is the accepted count, for reads the following bytes are data,
// forwarded only on acknowledge and only up to the requested length.
// Assumes one reply per accepted request and rx_last on its final byte.
module aux_rx_dec #(
    parameter int LEN_W = 5,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    input  logic             ctx_read,
    input  logic [LEN_W-1:0] ctx_len,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             rsp_done,
    output logic [3:0]       rsp_code,
    output logic [LEN_W-1:0] rsp_wcount,
    output logic [LEN_W-1:0] rsp_rcount
);
    import aux_frm_pkg::*;

    logic [CNT_W-1:0] ridx;
    logic [3:0]       code_q;
    logic [7:0]       wbyte_q;
    logic [LEN_W-1:0] dcnt;
    logic [3:0]       code_now;
    logic             take_data;
    logic [LEN_W-1:0] dcnt_nxt;
    logic [7:0]       wsel;
    logic [LEN_W-1:0] wclamp;

    // Current reply code and data-forwarding decision for this byte.
    always_comb begin
        code_now  = (ridx == '0) ? rx_data[7:4] : code_q;
        take_data = rx_valid && (ridx != '0) && ctx_read &&
                    (code_q == REPLY_ACK) && (dcnt < ctx_len);
        dcnt_nxt  = dcnt + LEN_W'(take_data);
    end

    // Written count: requested length when absent, else clamped reply byte.
    always_comb begin
        wsel = (ridx == CNT_W'(1)) ? rx_data : wbyte_q;
        if (ridx == '0)
            wclamp = ctx_len;
        else if (int'(wsel) > int'(ctx_len))
            wclamp = ctx_len;
        else
            wclamp = LEN_W'(wsel);
    end

    // Byte position tracking, field capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ridx       <= '0;
            code_q     <= '0;
            wbyte_q    <= '0;
            dcnt       <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            rsp_done   <= 1'b0;
            rsp_code   <= '0;
            rsp_wcount <= '0;
            rsp_rcount <= '0;
        end else begin
            rd_valid <= take_data;
            rsp_done <= 1'b0;
            if (take_data) rd_data <= rx_data;
            if (rx_valid) begin
                if (ridx == '0)         code_q  <= rx_data[7:4];
                if (ridx == CNT_W'(1))  wbyte_q <= rx_data;
                if (rx_last) begin
                    ridx       <= '0;
                    dcnt       <= '0;
                    rsp_done   <= 1'b1;
                    rsp_code   <= code_now;
                    rsp_wcount <= ctx_read ? '0 : wclamp;
                    rsp_rcount <= (ctx_read && code_now == REPLY_ACK) ? dcnt_nxt : '0;
                end else begin
                    dcnt <= dcnt_nxt;
                    if (ridx != '1) ridx <= ridx + CNT_W'(1);
                end
            end
        end
    end

    // R11
    ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (code_q == REPLY_ACK));
    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(rx_valid && rx_last));
    // R9
    wcount_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rsp_wcount <= $past(ctx_len)));
    // R10
    rcount_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rsp_rcount <= $past(ctx_len)));
endmodule

// File: rtl/aux_req_framer.sv
// aux_req_framer: top level. Decodes the request descriptor, sequences
// the transmit stream and decodes the matching reply. Assumes a reply is
// fed only after its request has been accepted.
module aux_req_framer #(
    parameter int LEN_W    = 5,
    parameter int MAX_XFER = 20,
    localparam int CNT_W   = $clog2(MAX_XFER + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [3:0]       req_code,
    input  logic [19:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_ready,
    output logic             req_reject,
    output logic             pay_take,
    input  logic [7:0]       pay_data,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic [CNT_W-1:0] tx_count,
    output logic [CNT_W-1:0] rx_expect,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    output logic             rsp_done,
    output logic [3:0]       rsp_code,
    output logic [LEN_W-1:0] rsp_wcount,
    output logic [LEN_W-1:0] rsp_rcount,
    output logic             rd_valid,
    output logic [7:0]       rd_data
);
    logic [3:0][7:0]  hdr;
    logic [2:0]       hdr_n;
    logic [CNT_W-1:0] tx_n;
    logic [CNT_W-1:0] rx_n;
    logic             is_read;
    logic             too_big;
    logic             ctx_read;
    logic [LEN_W-1:0] ctx_len;

    aux_hdr_gen #(.LEN_W(LEN_W), .CNT_W(CNT_W), .MAX_XFER(MAX_XFER)) u_hdr (
        .code(req_code), .addr(req_addr), .len(req_len),
        .hdr(hdr), .hdr_n(hdr_n), .tx_n(tx_n), .rx_n(rx_n),
        .is_read(is_read), .too_big(too_big)
    );

    aux_tx_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .req_go(req_valid), .too_big(too_big),
        .hdr_in(hdr), .hdr_n_in(hdr_n), .tx_n_in(tx_n), .rx_n_in(rx_n),
        .is_read_in(is_read), .len_in(req_len), .pay_data(pay_data),
        .ready(req_ready), .pay_take(pay_take), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_count(tx_count),
        .rej(req_reject), .ctx_read(ctx_read), .ctx_len(ctx_len),
        .ctx_rxn(rx_expect)
    );

    aux_rx_dec #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .ctx_read(ctx_read), .ctx_len(ctx_len),
        .rd_valid(rd_valid), .rd_data(rd_data), .rsp_done(rsp_done),
        .rsp_code(rsp_code), .rsp_wcount(rsp_wcount), .rsp_rcount(rsp_rcount)
    );
endmodule

// File: tb/aux_req_framer_test.sv
module aux_req_framer_test;
    localparam int LEN_W = 5;
    localparam int CNT_W = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [3:0]       req_code = '0;
    logic [19:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             req_ready, req_reject, pay_take;
    logic [7:0]       pay_data = '0;
    logic             tx_valid, tx_last;
    logic [7:0]       tx_data;
    logic [CNT_W-1:0] tx_count, rx_expect;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_data = '0;
    logic             rx_last = 1'b0;
    logic             rsp_done, rd_valid;
    logic [3:0]       rsp_code;
    logic [LEN_W-1:0] rsp_wcount, rsp_rcount;
    logic [7:0]       rd_data;

    aux_req_framer #(.LEN_W(LEN_W), .MAX_XFER(20)) uut (.*);

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] got[0:31];
    logic [7:0] rxb[0:31];
    logic [7:0] rdg[0:31];

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Issue a descriptor and capture the whole transmit stream, then compare.
    task automatic run_req(input string tag, input logic [3:0] code, input logic [19:0] addr,
                           input int len, input logic [7:0] base);
        int gn = 0, took = 0, exp_n;
        bit rd = code[0];
        logic [7:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_code = code; req_addr = addr; req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R7 no reject"}, int'(req_reject), 0);
        for (int c = 0; c < 40; c++) begin
            if (tx_valid) begin
                got[gn] = tx_data; gn++;
                if (tx_last) break;
            end
            if (pay_take) begin pay_data = base + 8'(took); took++; end
            @(negedge clk);
        end
        exp_n = rd ? (len != 0 ? 4 : 3) : (len != 0 ? 4 + len : 3);
        chk({tag, " R6 stream length"}, gn, exp_n);
        chk({tag, " R6 tx_count"}, int'(tx_count), exp_n);
        chk({tag, " R4/R5 payload pulls"}, took, rd ? 0 : len);
        chk({tag, " R4/R5 rx_expect"}, int'(rx_expect), rd ? len + 1 : 2);
        for (int i = 0; i < exp_n && i < gn; i++) begin
            case (i)
                0: e = {code, addr[19:16]};
                1: e = addr[15:8];
                2: e = addr[7:0];
                3: e = 8'(len - 1);
                default: e = base + 8'(i - 4);
            endcase
            chk($sformatf("%s R2/R3/R4 byte %0d", tag, i), int'(got[i]), int'(e));
        end
        @(negedge clk);
        chk({tag, " R6 stream ends"}, int'(tx_valid), 0);
    endtask

    // Feed n reply bytes from rxb and check the decoded result.
    task automatic run_rsp(input string tag, input int n, input int e_code,
                           input int e_w, input int e_r);
        int rn = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (rd_valid) begin rdg[rn] = rd_data; rn++; end
            rx_valid = 1'b1; rx_data = rxb[k]; rx_last = (k == n - 1);
        end
        @(negedge clk);
        if (rd_valid) begin rdg[rn] = rd_data; rn++; end
        rx_valid = 1'b0; rx_last = 1'b0;
        chk({tag, " R8 rsp_done"}, int'(rsp_done), 1);
        chk({tag, " R8 rsp_code"}, int'(rsp_code), e_code);
        chk({tag, " R9 rsp_wcount"}, int'(rsp_wcount), e_w);
        chk({tag, " R10/R11 rsp_rcount"}, int'(rsp_rcount), e_r);
        chk({tag, " R10/R11 data bytes out"}, rn, e_r);
        for (int i = 0; i < rn && i < e_r; i++)
            chk($sformatf("%s R10 data %0d", tag, i), int'(rdg[i]), int'(rxb[i + 1]));
        @(negedge clk);
        chk({tag, " R8 done is a pulse"}, int'(rsp_done), 0);
    endtask

    // Oversize descriptor: refused with no stream and no payload pull.
    task automatic run_reject(input string tag, input logic [3:0] code, input int len);
        int seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_code = code; req_addr = 20'hABCDE; req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R7 reject pulse"}, int'(req_reject), 1);
        for (int c = 0; c < 8; c++) begin
            if (tx_valid || pay_take) seen++;
            @(negedge clk);
        end
        chk({tag, " R7 no stream"}, seen, 0);
        chk({tag, " R7 still ready"}, int'(req_ready), 1);
        chk({tag, " R7 pulse ended"}, int'(req_reject), 0);
    endtask

    task automatic t_reset;
        chk("R1 tx_valid", int'(tx_valid), 0);
        chk("R1 tx_last", int'(tx_last), 0);
        chk("R1 req_reject", int'(req_reject), 0);
        chk("R1 pay_take", int'(pay_take), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 rsp_done", int'(rsp_done), 0);
        chk("R1 req_ready", int'(req_ready), 1);
    endtask

    task automatic t_writes;
        run_req("wr3", 4'h8, 20'h5A3C1, 3, 8'h30);
        rxb[0] = 8'h00; rxb[1] = 8'h02;
        run_rsp("wr3 short", 2, 0, 2, 0);
        run_req("wr5", 4'h0, 20'h12345, 5, 8'h40);
        rxb[0] = 8'h00;
        run_rsp("wr5 one byte", 1, 0, 5, 0);
        rxb[0] = 8'h00; rxb[1] = 8'h09;
        run_rsp("wr5 clamp", 2, 0, 5, 0);
        rxb[0] = 8'h10; rxb[1] = 8'h03;
        run_rsp("wr5 nack", 2, 1, 3, 0);
        run_req("wr0", 4'h8, 20'hF00FF, 0, 8'h00);
        run_req("wr16", 4'h8, 20'h00001, 16, 8'hA0);
    endtask

    task automatic t_reads;
        run_req("rd16", 4'h9, 20'h00200, 16, 8'h00);
        rxb[0] = 8'h00;
        for (int i = 1; i < 20; i++) rxb[i] = 8'hC0 + 8'(i);
        run_rsp("rd16 ack", 17, 0, 0, 16);
        run_rsp("rd16 surplus", 19, 0, 0, 16);
        run_req("rd4", 4'h9, 20'h00010, 4, 8'h00);
        rxb[0] = 8'h10;
        run_rsp("rd4 nack", 5, 1, 0, 0);
        rxb[0] = 8'h20;
        run_rsp("rd4 defer", 5, 2, 0, 0);
        run_req("rd0", 4'h1, 20'h7FFFF, 0, 8'h00);
        run_req("rd19", 4'h9, 20'h00300, 19, 8'h00);
    endtask

    task automatic t_limits;
        run_reject("wr17", 4'h8, 17);
        run_reject("rd20", 4'h9, 20);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R6 watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_writes();
        t_reads();
        t_limits();
        finish_run();
    end
endmodule